// File: doc/BRIEF.md
# Three-Symbol Serial Pattern Recognizer

This block watches a one-bit serial stream and flags every place where two consecutive `a` symbols are followed by a `b`. Symbol `a` is carried as a 0 on the input and symbol `b` as a 1. Each rising clock edge takes one symbol into the machine. The flag is a Mealy output. It is formed from the stored state and the live input, so it rises in the same cycle that the closing `b` is present.

The machine keeps only the useful prefix of the pattern in two D flip-flops. There are three codes: no prefix (00), a single `a` seen (01), and two or more `a` seen (10). The fourth code (11) is never entered. If it ever were, the next-state logic leaves it within one clock and the output stays low. An asynchronous active-low reset clears the state, and its release is synchronized to the clock inside the block.

Top module: `seq3_recognizer`

## Requirements
- R1: While `rst_n` is low, `hit` is 0 for any value of `sym`. Symbols taken during reset, or during the two clocks of reset release, form no part of a pattern.
- R2: With `sym` 0 = a and 1 = b, `hit` is 1 in a cycle exactly when `sym` is 1 and the two preceding accepted symbols were both 0. In every other cycle `hit` is 0.
- R3: A run of more than two `a` symbols followed by `b` still detects. For example, the stream a,a,a,b gives `hit` = 0,0,0,1.
- R4: After a detection the prefix is cleared, so a new detection needs two fresh `a` symbols. The stream a,a,b,a,a,b gives two hits, and the stream a,a,b,a,b gives one.
- R5: `hit` follows `sym` combinationally within the cycle, with no register between them.
- R6: The state register holds only the codes 00, 01 and 10. From code 11 the next-state logic moves to a legal code in one clock and `hit` is 0.
- R7: Streams that lack two consecutive `a` before a `b` never detect. Examples are a,b,a,b and runs of `b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym | input | 1 | Serial symbol: 0 = a, 1 = b |
| hit | output | 1 | High in the cycle the a,a,b pattern completes |

## Verification
The bench targets a long `a` run closing on `b`. A machine that lost the "two or more" state would miss that hit. It also targets back-to-back patterns sharing no symbols, where a design that kept its prefix after a hit would raise a false second hit on a,a,b,a,b. A reset placed between two `a` symbols and a `b` catches a design that keeps history across reset. Toggling the input within one cycle while in the two-`a` state catches a registered output, which would show the flag one clock late. Every 10-symbol stream is then swept against an arithmetic history model.

// File: rtl/seq3_pkg.sv
package seq3_pkg;
  localparam int STATE_W = 2;
  localparam int SYNC_STAGES = 2;
  localparam logic [STATE_W-1:0] ST_IDLE  = 2'b00;
  localparam logic [STATE_W-1:0] ST_ONE_A = 2'b01;
  localparam logic [STATE_W-1:0] ST_TWO_A = 2'b10;
endpackage

// File: rtl/seq3_rst_sync.sv
module seq3_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/seq3_next.sv
module seq3_next
  import seq3_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  logic               sym,
  output logic [STATE_W-1:0] nxt
);
  // Code 11 is unreachable; these equations send it to 10 on a, 00 on b.
  always_comb begin
    nxt[1] = ~sym & (cur[0] | cur[1]);
    nxt[0] = ~sym & ~cur[1] & ~cur[0];
  end
endmodule

// File: rtl/seq3_out.sv
module seq3_out
  import seq3_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  logic               sym,
  output logic               hit
);
  // Decoding cur[0] low keeps the unused code 11 silent.
  always_comb hit = cur[1] & ~cur[0] & sym;
endmodule

// File: rtl/seq3_recognizer.sv
module seq3_recognizer
  import seq3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sym,
  output logic hit
);
  logic               rst_sync_n;
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;

  seq3_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  seq3_next u_next (
    .cur (state_q),
    .sym (sym),
    .nxt (state_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  seq3_out u_out (
    .cur (state_q),
    .sym (sym),
    .hit (hit)
  );
endmodule

// File: rtl/seq3_recognizer_chk.sv
module seq3_recognizer_chk
  import seq3_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rst_q,
  input logic               sym,
  input logic               hit,
  input logic [STATE_W-1:0] st
);
  logic [1:0] seen;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)            seen <= 2'd0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !hit);

  p_hit_needs_prefix_r2: assert property (@(posedge clk) disable iff (!rst_q)
    hit |-> (seen == 2'd2 && sym && !$past(sym) && !$past(sym, 2)));

  p_prefix_gives_hit_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (seen == 2'd2 && sym && !$past(sym) && !$past(sym, 2)) |-> hit);

  p_clear_after_hit_r4: assert property (@(posedge clk) disable iff (!rst_q)
    hit |=> st == ST_IDLE);

  p_legal_code_r6: assert property (@(posedge clk) disable iff (!rst_q)
    st != 2'b11);

  p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_IDLE || st == ST_ONE_A) |-> !hit);
endmodule

bind seq3_recognizer seq3_recognizer_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .rst_q (rst_sync_n),
  .sym   (sym),
  .hit   (hit),
  .st    (state_q)
);

// File: tb/seq3_recognizer_test.sv
`timescale 1ns/1ps
module seq3_recognizer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym = 1'b1;
  logic hit;
  int   checks = 0;
  int   errors = 0;
  bit   h1 = 1'b1;
  bit   h2 = 1'b1;

  always #2.5 clk = ~clk;

  seq3_recognizer uut (.clk(clk), .rst_n(rst_n), .sym(sym), .hit(hit));

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input string tag);
    @(negedge clk);
    sym = v;
    #1;
    check(hit, v & ~h1 & ~h2, tag);
    @(posedge clk);
    h2 = h1;
    h1 = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sym = 1'b0;
    #1 check(hit, 1'b0, "R1");
    @(negedge clk);
    sym = 1'b1;
    #1 check(hit, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    h1 = 1'b1;
    h2 = 1'b1;
  endtask

  task automatic run(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) step(s[i] == "b", tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (expected completion)");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    run("aaab", "R3");
    run("bbaaaaaab", "R3");
    run("baabaab", "R4");
    run("baabab", "R4");
    run("bababbb", "R7");
    // R5: live input change inside one cycle while two a's are held
    run("baa", "R5");
    @(negedge clk);
    sym = 1'b0; #1 check(hit, 1'b0, "R5");
    sym = 1'b1; #1 check(hit, 1'b1, "R5");
    sym = 1'b0; #1 check(hit, 1'b0, "R5");
    @(posedge clk);
    h2 = h1; h1 = 1'b0;
    // R1: reset between the prefix and the closing b clears history
    do_reset();
    run("b", "R1");
    run("aab", "R6");
    // R2: every 10-symbol stream
    for (int v = 0; v < 1024; v++)
      for (int i = 9; i >= 0; i--) step(v[i], "R2");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule